// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

A small processor with a 4-bit accumulator, a carry flag, a zero flag and an 8-bit program counter. Each instruction is one byte. The high nibble selects one of sixteen operations, and the low nibble is an immediate value or a data-word address. Instructions come from an external memory with a registered read port. The core presents its program counter as the fetch address, and the memory returns that byte one clock later. Sixteen 4-bit data words are held inside the core in a RAM with synchronous reads.

Every instruction takes three clock cycles: fetch, decode with operand read, and execute. Architectural state changes only at the end of the execute cycle. The operand for each operation comes from an internal bus. That bus is the bitwise OR of three gated drivers: the immediate nibble, the RAM read data and the accumulator. At most one of these drivers is enabled at a time. The `step_i` input gates every state change, so a debugger can advance the core one clock at a time. HALT stops the core until reset.

Top module: `acc4_core`

## Requirements
- R1: While `rst_ni` is low, the core holds the program counter, accumulator, carry flag, zero flag and halted status at zero.
- R2: An instruction's results appear on the outputs three rising edges after its fetch cycle begins. The program counter changes only at the end of the execute cycle.
- R3: Opcodes are encoded in the high nibble as follows: 0 LDI, 1 LDA, 2 STOA, 3 STOB, 4 ADD, 5 ADDI, 6 ADDC, 7 SUB, 8 SUBI, 9 SUBC, A SJMP, B JMP, C BNEZ, D BEZ, E HALT, F NOOP. LDI loads the low nibble (IV) and LDA loads RAM[IV]. Both set the zero flag from the loaded value and leave carry unchanged.
- R4: STOA writes the accumulator to RAM[IV]. STOB writes the bus value to RAM[IV], and during a store that bus carries IV, so RAM[IV] becomes IV.
- R5: ADD and ADDI add RAM[IV] or IV to the accumulator. Carry takes the carry-out and zero is set when the 4-bit result is 0.
- R6: SUB and SUBI subtract RAM[IV] or IV from the accumulator. Carry is set on borrow (underflow) and zero is set when the result is 0.
- R7: ADDC adds RAM[IV] plus carry. SUBC subtracts RAM[IV] and then carry. Both update carry and zero the same way as R5 and R6.
- R8: SJMP replaces only the low nibble of the program counter with IV. JMP loads the program counter with {accumulator, IV}.
- R9: BNEZ performs the JMP load when zero is clear, and BEZ does so when zero is set. Otherwise both advance the program counter by one.
- R10: HALT sets the halted output and leaves the program counter where it is. From then until reset, no state changes.
- R11: Stores, jumps, branches and NOOP leave both flags unchanged. NOOP only advances the program counter.
- R12: While `step_i` is low, no register changes. Execution resumes from the same phase when `step_i` returns high.
- R13: At most one internal bus driver is enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance enable; low freezes the core |
| instr_i | input | 8 | Instruction byte, registered by memory from last cycle's `pc_o` |
| pc_o | output | 8 | Program counter, also the fetch address |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| halted_o | output | 1 | Core has executed HALT |

## Verification
An instruction that starts fetching in cycle n updates the accumulator, flags, RAM and program counter on edge n+3. During the two cycles before that edge, every output must keep its previous value. RAM contents show up only through a later LDA, which takes a further three edges. The bench runs a behavioural model that counts the same three phases and honours `step_i`. It compares all outputs at each falling edge, so a result that arrives one edge early or late is caught in that same cycle. Directed checks at fixed edge counts after reset pin down the three-cycle latency, and the final state of each program is checked as well.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  typedef enum logic [3:0] {
    OP_LDI, OP_LDA, OP_STOA, OP_STOB, OP_ADD, OP_ADDI, OP_ADDC, OP_SUB,
    OP_SUBI, OP_SUBC, OP_SJMP, OP_JMP, OP_BNEZ, OP_BEZ, OP_HALT, OP_NOOP
  } op_e;

  typedef enum logic [1:0] {PH_FETCH, PH_DECODE, PH_EXEC} phase_e;

  typedef enum logic [1:0] {PC_INC, PC_LOW, PC_LONG, PC_HOLD} pc_mode_e;

  localparam int SRC_IMM = 0;
  localparam int SRC_RAM = 1;
  localparam int SRC_ACC = 2;
  localparam int SRC_N   = 3;
endpackage

// File: rtl/acc4_alu.sv
module acc4_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W:0] t;

  always_comb begin
    if (sub_i) t = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    else       t = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end

  assign res_o  = t[W-1:0];
  assign cout_o = t[W];  // carry-out or borrow
endmodule

// File: rtl/acc4_ram.sv
module acc4_ram #(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/acc4_ctrl.sv
module acc4_ctrl
  import acc4_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               halted_i,
  input  op_e                op_i,
  input  logic               zero_i,
  output phase_e             phase_o,
  output logic [SRC_N-1:0]   bus_sel_o,
  output logic               acc_we_o,
  output logic               alu_en_o,
  output logic               alu_sub_o,
  output logic               alu_cin_o,
  output logic               ram_we_o,
  output pc_mode_e           pc_mode_o,
  output logic               halt_set_o
);
  logic adv;
  assign adv = step_i && !halted_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= PH_FETCH;
    else if (adv) begin
      unique case (phase_o)
        PH_FETCH:  phase_o <= PH_DECODE;
        PH_DECODE: phase_o <= PH_EXEC;
        default:   phase_o <= PH_FETCH;
      endcase
    end
  end

  always_comb begin
    bus_sel_o  = '0;
    acc_we_o   = 1'b0;
    alu_en_o   = 1'b0;
    alu_sub_o  = 1'b0;
    alu_cin_o  = 1'b0;
    ram_we_o   = 1'b0;
    pc_mode_o  = PC_INC;
    halt_set_o = 1'b0;
    if (phase_o == PH_EXEC) begin
      unique case (op_i)
        OP_LDI:  begin bus_sel_o[SRC_IMM] = 1'b1; acc_we_o = 1'b1; end
        OP_LDA:  begin bus_sel_o[SRC_RAM] = 1'b1; acc_we_o = 1'b1; end
        OP_STOA: begin bus_sel_o[SRC_ACC] = 1'b1; ram_we_o = 1'b1; end
        OP_STOB: begin bus_sel_o[SRC_IMM] = 1'b1; ram_we_o = 1'b1; end
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
          bus_sel_o[SRC_RAM] = 1'b1; acc_we_o = 1'b1; alu_en_o = 1'b1;
          alu_sub_o = (op_i == OP_SUB) || (op_i == OP_SUBC);
          alu_cin_o = (op_i == OP_ADDC) || (op_i == OP_SUBC);
        end
        OP_ADDI, OP_SUBI: begin
          bus_sel_o[SRC_IMM] = 1'b1; acc_we_o = 1'b1; alu_en_o = 1'b1;
          alu_sub_o = (op_i == OP_SUBI);
        end
        OP_SJMP: begin bus_sel_o[SRC_IMM] = 1'b1; pc_mode_o = PC_LOW; end
        OP_JMP:  begin bus_sel_o[SRC_IMM] = 1'b1; pc_mode_o = PC_LONG; end
        OP_BNEZ: begin bus_sel_o[SRC_IMM] = 1'b1; pc_mode_o = zero_i ? PC_INC : PC_LONG; end
        OP_BEZ:  begin bus_sel_o[SRC_IMM] = 1'b1; pc_mode_o = zero_i ? PC_LONG : PC_INC; end
        OP_HALT: begin pc_mode_o = PC_HOLD; halt_set_o = 1'b1; end
        default: ;
      endcase
    end
  end

  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_o)); // R12
endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [2*DATA_W-1:0] instr_i,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0]   acc_o,
  output logic                carry_o,
  output logic                zero_o,
  output logic                halted_o
);
  localparam int IW   = 2 * DATA_W;
  localparam int PC_W = 2 * DATA_W;

  phase_e             phase;
  logic [IW-1:0]      ir;
  op_e                op;
  logic [DATA_W-1:0]  iv, ram_q, bus, alu_res;
  logic               alu_cout;
  logic [SRC_N-1:0]   bus_sel;
  logic [DATA_W-1:0]  drv [SRC_N];
  logic               acc_we, alu_en, alu_sub, alu_cin, ram_we, halt_set;
  pc_mode_e           pc_mode;
  logic               exec_en, dec_en;

  assign op = op_e'(ir[IW-1:DATA_W]);
  assign iv = ir[DATA_W-1:0];
  assign dec_en  = step_i && !halted_o && (phase == PH_DECODE);
  assign exec_en = step_i && !halted_o && (phase == PH_EXEC);

  acc4_ctrl u_ctrl (
    .clk_i, .rst_ni, .step_i,
    .halted_i   (halted_o),
    .op_i       (op),
    .zero_i     (zero_o),
    .phase_o    (phase),
    .bus_sel_o  (bus_sel),
    .acc_we_o   (acc_we),
    .alu_en_o   (alu_en),
    .alu_sub_o  (alu_sub),
    .alu_cin_o  (alu_cin),
    .ram_we_o   (ram_we),
    .pc_mode_o  (pc_mode),
    .halt_set_o (halt_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ir <= {4'(OP_NOOP), {DATA_W{1'b0}}};
    else if (dec_en) ir <= instr_i;
  end

  acc4_ram #(.W(DATA_W), .AW(DATA_W)) u_ram (
    .clk_i, .rst_ni,
    .re_i    (dec_en),
    .raddr_i (instr_i[DATA_W-1:0]),
    .rdata_o (ram_q),
    .we_i    (exec_en && ram_we),
    .waddr_i (iv),
    .wdata_i (bus)
  );

  // wired-OR bus: each driver gated by its select
  assign drv[SRC_IMM] = iv;
  assign drv[SRC_RAM] = ram_q;
  assign drv[SRC_ACC] = acc_o;

  always_comb begin
    bus = '0;
    for (int i = 0; i < SRC_N; i++) bus |= drv[i] & {DATA_W{bus_sel[i]}};
  end

  acc4_alu #(.W(DATA_W)) u_alu (
    .a_i    (acc_o),
    .b_i    (bus),
    .cin_i  (alu_cin && carry_o),
    .sub_i  (alu_sub),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      pc_o     <= '0;
      halted_o <= 1'b0;
    end else if (exec_en) begin
      if (acc_we) begin
        acc_o  <= alu_en ? alu_res : bus;
        zero_o <= ((alu_en ? alu_res : bus) == '0);
      end
      if (alu_en) carry_o <= alu_cout;
      if (halt_set) halted_o <= 1'b1;
      unique case (pc_mode)
        PC_INC:  pc_o <= pc_o + 1'b1;
        PC_LOW:  pc_o <= {pc_o[PC_W-1:DATA_W], bus};
        PC_LONG: pc_o <= {acc_o, bus};
        default: ;
      endcase
    end
  end

  AST_BUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_sel)); // R13
  AST_PC_EXEC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_EXEC) |=> $stable(pc_o)); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pc_o) && $stable(acc_o) && $stable(carry_o) && $stable(zero_o)); // R10
  AST_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && (op inside {OP_STOA, OP_STOB, OP_SJMP, OP_JMP, OP_BNEZ, OP_BEZ, OP_NOOP}))
    |=> $stable(carry_o) && $stable(zero_o)); // R11
  AST_STEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(acc_o) && $stable(halted_o)); // R12
endmodule

// File: tb/acc4_core_tb_top.sv
module acc4_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b1;
  logic [7:0] imem_q = 8'h00;
  logic [7:0] pc;
  logic [3:0] acc;
  logic       carry, zero, halted;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  acc4_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .instr_i(imem_q),
    .pc_o(pc), .acc_o(acc), .carry_o(carry), .zero_o(zero), .halted_o(halted)
  );

  logic [7:0] prog [256];
  always @(posedge clk) imem_q <= prog[pc];

  // behavioural reference model
  int m_phase, m_acc, m_c, m_z, m_pc, m_h;
  int m_ram [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_acc = 0; m_c = 0; m_z = 0; m_pc = 0; m_h = 0;
    end else if (step && !m_h) begin
      if (m_phase < 2) m_phase++;
      else begin
        int opc, v, r;
        m_phase = 0;
        opc = prog[m_pc] >> 4;
        v   = prog[m_pc] & 15;
        r   = 0;
        case (opc)
          0:  begin m_acc = v; m_z = (v == 0); end
          1:  begin m_acc = m_ram[v]; m_z = (m_acc == 0); end
          2:  m_ram[v] = m_acc;
          3:  m_ram[v] = v;
          4, 5, 6: begin
            r = m_acc + ((opc == 5) ? v : m_ram[v]) + ((opc == 6) ? m_c : 0);
            m_c = (r > 15); m_acc = r & 15; m_z = (m_acc == 0);
          end
          7, 8, 9: begin
            r = m_acc - ((opc == 8) ? v : m_ram[v]) - ((opc == 9) ? m_c : 0);
            m_c = (r < 0); m_acc = r & 15; m_z = (m_acc == 0);
          end
          default: ;
        endcase
        if (opc == 10) m_pc = (m_pc & 8'hF0) | v;
        else if (opc == 11 || (opc == 12 && !m_z) || (opc == 13 && m_z)) m_pc = (m_acc << 4) | v;
        else if (opc == 14) m_h = 1;
        else m_pc = (m_pc + 1) & 255;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lockstep compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check({pc, acc, carry, zero, halted} == {m_pc[7:0], m_acc[3:0], m_c[0], m_z[0], m_h[0]},
            tag, "lockstep {pc,acc,c,z,h}",
            int'({pc, acc, carry, zero, halted}),
            int'({m_pc[7:0], m_acc[3:0], m_c[0], m_z[0], m_h[0]}));
    end
  end

  task automatic load(input logic [7:0] img [$]);
    for (int i = 0; i < 256; i++) prog[i] = 8'hF0;
    foreach (img[i]) prog[i] = img[i];
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; step = 1'b1;
    @(negedge clk);
    check({pc, acc, carry, zero, halted} == 15'h0, "R1", "reset state",
          int'({pc, acc, carry, zero, halted}), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run(int max_cyc);
    for (int i = 0; i < max_cyc && !halted; i++) @(negedge clk);
  endtask

  task automatic final_state(string req, int e_pc, int e_acc, int e_c, int e_z);
    check(pc == e_pc[7:0], req, "pc", pc, e_pc);
    check(acc == e_acc[3:0], req, "acc", acc, e_acc);
    check(carry == e_c[0], req, "carry", carry, e_c);
    check(zero == e_z[0], req, "zero", zero, e_z);
    check(halted == 1'b1, req, "halted", halted, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_ram[i] = 0;
    load('{8'h0F});
    #1;
    // T1: loads, stores, NOOP, latency (R2, R3, R4)
    load('{8'h05, 8'h23, 8'h00, 8'h13, 8'h37, 8'h17, 8'hF0, 8'hE0});
    tag = "R3";
    do_reset();
    @(negedge clk); @(negedge clk);
    check(pc == 0 && acc == 0, "R2", "no result before 3rd edge", int'({pc, acc}), 0);
    @(negedge clk);
    check(pc == 1 && acc == 5, "R2", "result on 3rd edge", int'({pc, acc}), 'h015);
    run(100);
    final_state("R4", 7, 7, 0, 0);

    // T2: flags unchanged by store/jump/noop, SJMP skip (R11, R8)
    load('{8'h0F, 8'h51, 8'h22, 8'h34, 8'hF0, 8'hA7, 8'h03, 8'hE0});
    tag = "R11";
    do_reset();
    run(100);
    final_state("R11", 7, 0, 1, 1);

    // T3: add with carry chain (R5, R7)
    load('{8'h0F, 8'h51, 8'h09, 8'h20, 8'h08, 8'h40, 8'h60, 8'hE0});
    tag = "R5";
    do_reset();
    run(100);
    final_state("R7", 7, 'hB, 0, 0);

    // T4: subtract with borrow chain (R6, R7)
    load('{8'h02, 8'h21, 8'h01, 8'h71, 8'h91, 8'h8C, 8'hE0});
    tag = "R6";
    do_reset();
    run(100);
    final_state("R6", 6, 0, 0, 1);

    // T5: long jump and branches (R8, R9)
    for (int i = 0; i < 256; i++) prog[i] = 8'hF0;
    prog[8'h00] = 8'h01; prog[8'h01] = 8'hB0;
    prog[8'h10] = 8'h00; prog[8'h11] = 8'hC5; prog[8'h12] = 8'hD4;
    prog[8'h04] = 8'hA8;
    prog[8'h08] = 8'h02; prog[8'h09] = 8'hDF; prog[8'h0A] = 8'hCB;
    prog[8'h2B] = 8'hE0;
    tag = "R9";
    do_reset();
    run(200);
    final_state("R9", 'h2B, 2, 0, 0);

    // T6: halted core stays frozen (R10)
    tag = "R10";
    for (int i = 0; i < 30; i++) @(negedge clk);
    final_state("R10", 'h2B, 2, 0, 0);

    // T7: step gating (R12)
    load('{8'h02, 8'h21, 8'h01, 8'h71, 8'h91, 8'h8C, 8'hE0});
    tag = "R12";
    do_reset();
    for (int i = 0; i < 7; i++) @(negedge clk);
    begin
      logic [7:0] p0; logic [3:0] a0;
      p0 = pc; a0 = acc;
      step = 1'b0;
      for (int i = 0; i < 6; i++) @(negedge clk);
      check(pc == p0 && acc == a0, "R12", "frozen while step low",
            int'({pc, acc}), int'({p0, a0}));
    end
    for (int i = 0; i < 120 && !halted; i++) begin
      step = (i % 3) != 1;
      @(negedge clk);
    end
    step = 1'b1;
    run(60);
    final_state("R12", 6, 0, 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule